// File: doc/BRIEF.md
# Software Store Sequence Detector

This block sits beside the access port of a 32K x 8 nonvolatile static RAM. It watches the control strobes and the 15-bit address, and turns them into discrete read and write events. It looks for one fixed ordered run of six reads. The first five reads go to set prefix addresses. The sixth read selects the action: one address asks for a nonvolatile store and another asks for a recall. When the run completes, the block raises a one-cycle request toward the store/recall controller.

Because the trigger uses only ordinary read cycles, the memory keeps the pinout of a plain SRAM. Reads made during matching still complete normally, since the detector only observes. A write, or a read that does not fit the next expected position, drops the partial match. The access that broke the match is then tested as a possible start of a new run. While the controller reports a transfer in progress, the detector holds its idle state and ignores all traffic.

Top module: `sw_store_detect`

## Requirements
- R1: A read is recognised only while ce_ni=0, oe_ni=0, we_ni=1 and hs_ni=1. A cycle with ce_ni=0 but oe_ni=1 and we_ni=1 is no access and leaves a partial match intact.
- R2: A write is recognised while ce_ni=0, we_ni=0 and hs_ni=1. A write attempt with hs_ni=0 is no access and leaves a partial match intact.
- R3: A read counts as one event when it starts. While the read strobes stay asserted, each change of addr_i counts as a new read event, and holding the same address adds no events.
- R4: Reads of PREFIX_ADDR[0..4] in that order, followed by a read of STORE_ADDR, give store_o=1 in the cycle after the sixth read is sampled.
- R5: The same prefix followed by a read of RECALL_ADDR gives recall_o=1 in the same relative cycle, and store_o stays 0.
- R6: store_o and recall_o are each high for exactly one cycle per completed run, and they are never high together.
- R7: A write event at any point of a partial match discards it, and the write never starts a new run.
- R8: A read whose address does not fit the next position discards the partial match. If that read equals PREFIX_ADDR[0], it counts as the first element of a new run.
- R9: While busy_i=1, the match is cleared, all accesses are ignored, and neither pulse is raised.
- R10: With hs_ni=0 or ce_ni=1, no read or write is recognised, so a full address run under those conditions gives no pulse.
- R11: While rst_ni=0 and after reset, store_o and recall_o are 0 and the match is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| hs_ni | input | 1 | Hardware store pin, active low; high for normal access |
| addr_i | input | 15 | Byte address |
| busy_i | input | 1 | Store/recall transfer in progress |
| store_o | output | 1 | One-cycle store request |
| recall_o | output | 1 | One-cycle recall request |

## Verification
The main run is tried with discrete reads separated by idle cycles, and with back-to-back reads that change only the address while the strobes stay low. Comparing these two shows whether events come from read starts or from address transitions. The same run is also broken by a write, by a wrong read that equals the first prefix address, and by a busy pulse. These cases separate "abort and restart" from "abort only" and from "ignore". Runs with hs_ni low, with output enable high, and with a write strobe but hs_ni low check that non-accesses neither count nor abort. A reference model compares both pulses on every cycle.

// File: rtl/sw_store_pkg.sv
package sw_store_pkg;
  localparam int ADDR_W     = 15;
  localparam int SEQ_LEN    = 6;
  localparam int PREFIX_LEN = SEQ_LEN - 1;
  localparam int STEP_W     = $clog2(SEQ_LEN);
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [STEP_W-1:0] step_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import sw_store_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ce_ni,
  input  logic  oe_ni,
  input  logic  we_ni,
  input  logic  hs_ni,
  input  addr_t addr_i,
  output logic  rd_ev_o,
  output logic  wr_ev_o
);
  logic  rd_lvl, wr_lvl, rd_q, wr_q;
  addr_t addr_q;

  assign rd_lvl = !ce_ni && !oe_ni && we_ni && hs_ni;
  assign wr_lvl = !ce_ni && !we_ni && hs_ni;

  // a held read restarts on every address transition
  assign rd_ev_o = rd_lvl && (!rd_q || (addr_i != addr_q));
  assign wr_ev_o = wr_lvl && !wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      rd_q   <= rd_lvl;
      wr_q   <= wr_lvl;
      addr_q <= addr_i;
    end
  end
endmodule

// File: rtl/seq_match.sv
module seq_match
  import sw_store_pkg::*;
#(
  parameter addr_t [PREFIX_LEN-1:0] PREFIX_ADDR = '0,
  parameter addr_t                  STORE_ADDR  = '0,
  parameter addr_t                  RECALL_ADDR = '1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  busy_i,
  input  logic  rd_ev_i,
  input  logic  wr_ev_i,
  input  addr_t addr_i,
  output logic  store_o,
  output logic  recall_o
);
  localparam int    HIT_N = 2**STEP_W;
  localparam step_t LAST  = step_t'(PREFIX_LEN);

  logic [HIT_N-1:0] pre_hit;
  step_t step_q, step_d, restart;
  logic  store_d, recall_d, cur_hit, st_hit, rc_hit;

  for (genvar g = 0; g < HIT_N; g++) begin : g_hit
    if (g < PREFIX_LEN) begin : g_cmp
      assign pre_hit[g] = (addr_i == PREFIX_ADDR[g]);
    end else begin : g_pad
      assign pre_hit[g] = 1'b0;
    end
  end

  assign cur_hit = pre_hit[step_q];
  assign st_hit  = (addr_i == STORE_ADDR);
  assign rc_hit  = (addr_i == RECALL_ADDR);
  // aborting read may open a new run
  assign restart = pre_hit[0] ? step_t'(1) : step_t'(0);

  always_comb begin
    step_d   = step_q;
    store_d  = 1'b0;
    recall_d = 1'b0;
    if (busy_i || wr_ev_i) begin
      step_d = '0;
    end else if (rd_ev_i) begin
      if (step_q == LAST) begin
        store_d  = st_hit;
        recall_d = rc_hit && !st_hit;
        step_d   = (st_hit || rc_hit) ? step_t'(0) : restart;
      end else if (cur_hit) begin
        step_d = step_q + step_t'(1);
      end else begin
        step_d = restart;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= '0;
      store_o  <= 1'b0;
      recall_o <= 1'b0;
    end else begin
      step_q   <= step_d;
      store_o  <= store_d;
      recall_o <= recall_d;
    end
  end
endmodule

// File: rtl/sw_store_detect.sv
module sw_store_detect
  import sw_store_pkg::*;
#(
  parameter addr_t [PREFIX_LEN-1:0] PREFIX_ADDR =
    {15'h3C3C, 15'h70F0, 15'h0F0F, 15'h25A3, 15'h1A5C},
  parameter addr_t STORE_ADDR  = 15'h4B4B,
  parameter addr_t RECALL_ADDR = 15'h34B4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ce_ni,
  input  logic        oe_ni,
  input  logic        we_ni,
  input  logic        hs_ni,
  input  logic [14:0] addr_i,
  input  logic        busy_i,
  output logic        store_o,
  output logic        recall_o
);
  logic rd_ev, wr_ev;

  acc_decode i_acc_decode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_ni   (ce_ni),
    .oe_ni   (oe_ni),
    .we_ni   (we_ni),
    .hs_ni   (hs_ni),
    .addr_i  (addr_i),
    .rd_ev_o (rd_ev),
    .wr_ev_o (wr_ev)
  );

  seq_match #(
    .PREFIX_ADDR (PREFIX_ADDR),
    .STORE_ADDR  (STORE_ADDR),
    .RECALL_ADDR (RECALL_ADDR)
  ) i_seq_match (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .busy_i   (busy_i),
    .rd_ev_i  (rd_ev),
    .wr_ev_i  (wr_ev),
    .addr_i   (addr_i),
    .store_o  (store_o),
    .recall_o (recall_o)
  );
endmodule

// File: rtl/sw_store_chk.sv
module sw_store_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ce_ni,
  input logic        oe_ni,
  input logic        we_ni,
  input logic        hs_ni,
  input logic [14:0] addr_i,
  input logic        busy_i,
  input logic        store_o,
  input logic        recall_o
);
  logic rd_lvl, wr_lvl;
  assign rd_lvl = !ce_ni && !oe_ni && we_ni && hs_ni;
  assign wr_lvl = !ce_ni && !we_ni && hs_ni;

  a_r6_store_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |=> !store_o);
  a_r6_recall_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_o |=> !recall_o);
  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(store_o && recall_o));
  a_r9_busy_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (!store_o && !recall_o));
  a_r7_write_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lvl |=> (!store_o && !recall_o));
  a_r1_pulse_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_o || recall_o) |-> $past(rd_lvl));
endmodule

bind sw_store_detect sw_store_chk i_sw_store_chk (.*);

// File: tb/test_sw_store_detect.sv
module test_sw_store_detect;
  localparam logic [14:0] P0 = 15'h1A5C, P1 = 15'h25A3, P2 = 15'h0F0F,
                          P3 = 15'h70F0, P4 = 15'h3C3C;
  localparam logic [14:0] ST = 15'h4B4B, RC = 15'h34B4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hs_n = 1'b1, busy = 1'b0;
  logic [14:0] addr = '0;
  logic store, recall;

  sw_store_detect #(
    .PREFIX_ADDR ({P4, P3, P2, P1, P0}),
    .STORE_ADDR  (ST),
    .RECALL_ADDR (RC)
  ) i_sw_store_detect (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .hs_ni(hs_n), .addr_i(addr), .busy_i(busy), .store_o(store), .recall_o(recall)
  );

  int checks = 0, fails = 0, st_cnt = 0, rc_cnt = 0;
  string cur_req = "R11";
  bit done = 1'b0;

  // reference model
  logic [14:0] seq_q[$] = '{P0, P1, P2, P3, P4};
  int  prog = 0;
  bit  exp_st = 0, exp_rc = 0, p_rd = 0, p_wr = 0;
  logic [14:0] p_addr = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog = 0; exp_st = 0; exp_rc = 0; p_rd = 0; p_wr = 0; p_addr = '0;
    end else begin
      bit rd, wr, rd_ev, wr_ev;
      rd = !ce_n && !oe_n && we_n && hs_n;
      wr = !ce_n && !we_n && hs_n;
      rd_ev = rd && (!p_rd || addr != p_addr);
      wr_ev = wr && !p_wr;
      exp_st = 0; exp_rc = 0;
      if (busy || wr_ev) prog = 0;
      else if (rd_ev) begin
        if (prog == seq_q.size()) begin
          if (addr == ST) begin exp_st = 1; prog = 0; end
          else if (addr == RC) begin exp_rc = 1; prog = 0; end
          else prog = (addr == seq_q[0]) ? 1 : 0;
        end else if (addr == seq_q[prog]) prog++;
        else prog = (addr == seq_q[0]) ? 1 : 0;
      end
      p_rd = rd; p_wr = wr; p_addr = addr;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (store !== exp_st || recall !== exp_rc) begin
        fails++;
        $display("FAIL %s cycle compare: store/recall=%b%b expected %b%b",
                 cur_req, store, recall, exp_st, exp_rc);
      end
      if (store === 1'b1) st_cnt++;
      if (recall === 1'b1) rc_cnt++;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    ce_n = 1; oe_n = 1; we_n = 1; hs_n = 1;
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [14:0] a);
    ce_n = 0; oe_n = 0; we_n = 1; addr = a;
    @(negedge clk);
    idle(1);
  endtask

  task automatic wr(logic [14:0] a);
    ce_n = 0; oe_n = 1; we_n = 0; addr = a;
    @(negedge clk);
    idle(1);
  endtask

  task automatic run(logic [14:0] last);
    for (int i = 0; i < 5; i++) rd(seq_q[i]);
    rd(last);
  endtask

  int s0, r0;
  task automatic snap(); s0 = st_cnt; r0 = rc_cnt; endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset store", int'(store), 0);
    chk("R11 reset recall", int'(recall), 0);
    rst_n = 1;
    idle(2);

    cur_req = "R4"; snap(); run(ST); idle(2);
    chk("R4 store pulses", st_cnt - s0, 1);
    chk("R6 single pulse, no recall", rc_cnt - r0, 0);

    cur_req = "R5"; snap(); run(RC); idle(2);
    chk("R5 recall pulses", rc_cnt - r0, 1);
    chk("R5 no store", st_cnt - s0, 0);

    cur_req = "R7"; snap();
    rd(P0); rd(P1); rd(P2); wr(P3); rd(P3); rd(P4); rd(ST); idle(2);
    chk("R7 write aborts", st_cnt - s0, 0);
    snap(); wr(P0); rd(P1); rd(P2); rd(P3); rd(P4); rd(ST); idle(2);
    chk("R7 write does not start", st_cnt - s0, 0);

    cur_req = "R8"; snap();
    rd(P0); rd(P1); rd(P2); rd(P0); rd(P1); rd(P2); rd(P3); rd(P4); rd(ST); idle(2);
    chk("R8 abort restarts on first addr", st_cnt - s0, 1);
    snap(); rd(P0); rd(P1); rd(15'h0123); rd(P2); rd(P3); rd(P4); rd(ST); idle(2);
    chk("R8 wrong read aborts", st_cnt - s0, 0);

    cur_req = "R3"; snap();
    ce_n = 0; oe_n = 0; we_n = 1;
    for (int i = 0; i < 5; i++) begin addr = seq_q[i]; @(negedge clk); end
    addr = ST; @(negedge clk); idle(2);
    chk("R3 address transitions count", st_cnt - s0, 1);
    snap(); ce_n = 0; oe_n = 0; we_n = 1; addr = P0;
    repeat (4) @(negedge clk);
    for (int i = 1; i < 5; i++) begin addr = seq_q[i]; @(negedge clk); end
    addr = RC; @(negedge clk); idle(2);
    chk("R3 held read counts once", rc_cnt - r0, 1);

    cur_req = "R1"; snap();
    rd(P0); rd(P1); rd(P2);
    ce_n = 0; oe_n = 1; we_n = 1; addr = 15'h7777; @(negedge clk); idle(1);
    rd(P3); rd(P4); rd(ST); idle(2);
    chk("R1 oe high is no access", st_cnt - s0, 1);

    cur_req = "R2"; snap();
    rd(P0); rd(P1);
    hs_n = 0; ce_n = 0; we_n = 0; oe_n = 1; addr = 15'h0001; @(negedge clk); idle(1);
    rd(P2); rd(P3); rd(P4); rd(ST); idle(2);
    chk("R2 write with hs low is no access", st_cnt - s0, 1);

    cur_req = "R10"; snap();
    for (int i = 0; i < 5; i++) begin
      hs_n = 0; ce_n = 0; oe_n = 0; we_n = 1; addr = seq_q[i]; @(negedge clk); idle(1);
    end
    hs_n = 0; ce_n = 0; oe_n = 0; addr = ST; @(negedge clk); idle(2);
    chk("R10 hs low run ignored", st_cnt - s0, 0);
    snap();
    for (int i = 0; i < 5; i++) begin
      ce_n = 1; oe_n = 0; addr = seq_q[i]; @(negedge clk); idle(1);
    end
    idle(2);
    chk("R10 ce high run ignored", st_cnt - s0, 0);

    cur_req = "R9"; snap();
    rd(P0); rd(P1); rd(P2); rd(P3);
    busy = 1; @(negedge clk); busy = 0;
    rd(P4); rd(ST); idle(2);
    chk("R9 busy clears match", st_cnt - s0, 0);
    snap(); busy = 1; run(ST); busy = 0; idle(2);
    chk("R9 busy ignores run", st_cnt - s0, 0);
    snap(); run(ST); idle(2);
    chk("R9 works after busy", st_cnt - s0, 1);

    cur_req = "R6"; snap(); run(ST); run(RC); idle(3);
    chk("R6 one store per run", st_cnt - s0, 1);
    chk("R6 one recall per run", rc_cnt - r0, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule